// File: doc/BRIEF.md
# Dual-Identity Two-Wire Bus Slave

This block is a two-wire serial bus slave that presents itself to a bus master as two independent devices sharing one pair of wires. One identity fronts a byte-addressed memory and the other a small clock/alarm register file. Both internal targets hang off simple synchronous register ports. The block runs entirely from a fast system clock. SCL and SDA are treated as slow asynchronous inputs: they are synchronized, edge-detected and decoded into Start, Stop and data-bit events.

A transaction opens with a Start and an address byte. If the upper nibble and the three device-select bits match one of the two identities, the slave acknowledges and binds the rest of the transaction to that target. In a write, the first data byte sets a word pointer and every later byte is written at the pointer, which then advances. In a read, the slave fetches a byte at the pointer and shifts it out, and keeps fetching and sending further bytes for as long as the master acknowledges. The pointer wraps inside the selected target's address range.

Top module: `dual_id_twi_slave`

## Requirements
- R1: An address byte clocked without a preceding Start (SDA falling while SCL is high) is ignored: no acknowledge and no target strobe.
- R2: A Start that arrives in the middle of a byte abandons the transfer, releases SDA, and the next eight bits are taken as a fresh address byte.
- R3: A Stop (SDA rising while SCL is high) abandons any pending byte: SDA is released, no strobe follows, and later bits are ignored until a Start.
- R4: The address byte is received MSB first. Bits 7:4 carry the identity, bits 3:1 must equal `dev_sel_i`, and bit 0 is 1 for read and 0 for write. A device-select mismatch gets no acknowledge.
- R5: Identity 4'b1010 routes the transaction to the memory port and identity 4'b1101 to the clock port. Any other identity is not acknowledged, and no strobe reaches either port until the next Start.
- R6: The slave pulls SDA low during the ninth clock after a matched address byte and after every byte written to it.
- R7: In a write, the first data byte loads the word pointer without a write. Each following byte gives exactly one single-cycle write strobe at the current pointer, and the pointer then advances by one.
- R8: The pointer wraps to 0 after the last location of the selected target: 2^MEM_AW-1 for memory and 2^RTC_AW-1 for the clock port.
- R9: In a read, a byte is fetched at the pointer when the address is acknowledged and is sent MSB first. Each master ACK advances the pointer and fetches and sends the next byte.
- R10: A master NACK ends the read. SDA is released, and no further fetch takes place.
- R11: The slave starts pulling SDA low only after synchronized SCL has been seen low.
- R12: In any cycle at most one of the four target strobes is active.
- R13: During and right after reset, SDA is released and all target strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel_i | input | 3 | Device-select value that address bits 3:1 must match |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr_o | output | MEM_AW | Memory word address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe, one cycle |
| mem_re_o | output | 1 | Memory read strobe, one cycle |
| mem_rdata_i | input | 8 | Memory read data, sampled in the read-strobe cycle |
| rtc_addr_o | output | RTC_AW | Clock register address |
| rtc_wdata_o | output | 8 | Clock register write data |
| rtc_we_o | output | 1 | Clock register write strobe, one cycle |
| rtc_re_o | output | 1 | Clock register read strobe, one cycle |
| rtc_rdata_i | input | 8 | Clock register read data, sampled in the read-strobe cycle |

## Verification
A bus-condition event and a data-bit event can land in the same synchronized cycle. An SDA edge during SCL high is taken as Start or Stop, but the SCL rise just before it has already shifted a bit into the byte being assembled. The bench provokes this by breaking off a write after a few bits, once with a repeated Start and once with a Stop. The outcome is judged at the ports: the write-strobe count stays unchanged, the following address byte is acknowledged or ignored as required, and a read-back shows that the target location kept its old value or took only the intended new one.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WRX,
        ST_WACK,
        ST_TX,
        ST_RACK
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [2:0]        cnt;
        logic              full;
        logic [BYTE_W-1:0] sr;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] addr;
        logic              tgt;
        logic              rw;
        logic              aphase;
        logic              inc;
        logic              mack;
        logic              fetch;
        logic              oe;
        logic              we;
        logic              re;
        logic [BYTE_W-1:0] wd;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, cnt: 3'd0, full: 1'b0, sr: '0, tx: '0, addr: '0,
        tgt: 1'b0, rw: 1'b0, aphase: 1'b0, inc: 1'b0, mack: 1'b0,
        fetch: 1'b0, oe: 1'b0, we: 1'b0, re: 1'b0, wd: '0
    };

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    for (genvar b = 0; b < W; b++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
        assign prev_o[b] = prev_q;
    end

endmodule

// File: rtl/twi_route.sv
module twi_route #(
    parameter int MEM_AW = 8,
    parameter int RTC_AW = 4
) (
    input  logic              sel_rtc_i,
    input  logic [7:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              we_i,
    input  logic              re_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [RTC_AW-1:0] rtc_addr_o,
    output logic [7:0]        rtc_wdata_o,
    output logic              rtc_we_o,
    output logic              rtc_re_o,
    input  logic [7:0]        rtc_rdata_i,
    output logic [7:0]        rdata_o
);

    assign mem_addr_o  = addr_i[MEM_AW-1:0];
    assign rtc_addr_o  = addr_i[RTC_AW-1:0];
    assign mem_wdata_o = wdata_i;
    assign rtc_wdata_o = wdata_i;
    assign mem_we_o    = we_i & ~sel_rtc_i;
    assign mem_re_o    = re_i & ~sel_rtc_i;
    assign rtc_we_o    = we_i &  sel_rtc_i;
    assign rtc_re_o    = re_i &  sel_rtc_i;
    assign rdata_o     = sel_rtc_i ? rtc_rdata_i : mem_rdata_i;

endmodule

// File: rtl/dual_id_twi_slave.sv
module dual_id_twi_slave
    import twi_pkg::*;
#(
    parameter int         MEM_AW      = 8,
    parameter int         RTC_AW      = 4,
    parameter logic [3:0] MEM_ID      = 4'b1010,
    parameter logic [3:0] RTC_ID      = 4'b1101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        dev_sel_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [RTC_AW-1:0] rtc_addr_o,
    output logic [7:0]        rtc_wdata_o,
    output logic              rtc_we_o,
    output logic              rtc_re_o,
    input  logic [7:0]        rtc_rdata_i
);

    localparam logic [BYTE_W-1:0] MEM_MASK = BYTE_W'((9'd1 << MEM_AW) - 9'd1);
    localparam logic [BYTE_W-1:0] RTC_MASK = BYTE_W'((9'd1 << RTC_AW) - 9'd1);

    // line synchronizers: bit 0 = SCL, bit 1 = SDA
    logic [1:0] line_s, line_p;

    twi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({sda_i, scl_i}),
        .sync_o (line_s),
        .prev_o (line_p)
    );

    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign scl_s     = line_s[0];
    assign sda_s     = line_s[1];
    assign scl_p     = line_p[0];
    assign sda_p     = line_p[1];
    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

    regs_t q, d;
    logic [7:0] rdata_sel;

    // address byte decode
    logic id_mem, id_rtc, id_hit;
    logic [BYTE_W-1:0] tgt_mask, addr_inc;

    assign id_mem   = (q.sr[7:4] == MEM_ID);
    assign id_rtc   = (q.sr[7:4] == RTC_ID);
    assign id_hit   = (id_mem | id_rtc) & (q.sr[3:1] == dev_sel_i);
    assign tgt_mask = q.tgt ? RTC_MASK : MEM_MASK;
    assign addr_inc = (q.addr + BYTE_W'(1)) & tgt_mask;

    always_comb begin
        d       = q;
        d.we    = 1'b0;
        d.re    = 1'b0;
        d.fetch = 1'b0;
        if (q.re) begin
            d.tx = rdata_sel;
        end
        if (q.fetch) begin
            d.re = 1'b1;
        end

        if (start_det) begin
            d.st    = ST_ADDR;
            d.cnt   = 3'd0;
            d.full  = 1'b0;
            d.oe    = 1'b0;
            d.re    = 1'b0;
            d.fetch = 1'b0;
        end else if (stop_det) begin
            d.st    = ST_IDLE;
            d.oe    = 1'b0;
            d.re    = 1'b0;
            d.fetch = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WRX: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_s};
                        d.cnt = 3'(q.cnt + 3'd1);
                        if (q.cnt == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        if (q.st == ST_ADDR) begin
                            if (id_hit) begin
                                d.tgt = id_rtc;
                                d.rw  = q.sr[0];
                                d.oe  = 1'b1;
                                d.st  = ST_AACK;
                                d.re  = q.sr[0];
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.st = ST_WACK;
                            if (q.aphase) begin
                                d.addr   = q.sr & tgt_mask;
                                d.aphase = 1'b0;
                            end else begin
                                d.we  = 1'b1;
                                d.wd  = q.sr;
                                d.inc = 1'b1;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = 3'd0;
                        if (q.rw) begin
                            d.st = ST_TX;
                            d.oe = ~q.tx[7];
                        end else begin
                            d.st     = ST_WRX;
                            d.oe     = 1'b0;
                            d.aphase = 1'b1;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.st  = ST_WRX;
                        d.cnt = 3'd0;
                        if (q.inc) begin
                            d.addr = addr_inc;
                            d.inc  = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.oe = 1'b0;
                            d.st = ST_RACK;
                        end else begin
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.oe  = ~q.tx[6];
                            d.cnt = 3'(q.cnt + 3'd1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                        if (!sda_s) begin
                            d.addr  = addr_inc;
                            d.fetch = 1'b1;
                        end
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.cnt = 3'd0;
                            d.oe  = ~q.tx[7];
                        end else begin
                            d.st = ST_IDLE;
                            d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= REGS_RST;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;

    twi_route #(.MEM_AW(MEM_AW), .RTC_AW(RTC_AW)) u_route (
        .sel_rtc_i   (q.tgt),
        .addr_i      (q.addr),
        .wdata_i     (q.wd),
        .we_i        (q.we),
        .re_i        (q.re),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_rdata_i (mem_rdata_i),
        .rtc_addr_o  (rtc_addr_o),
        .rtc_wdata_o (rtc_wdata_o),
        .rtc_we_o    (rtc_we_o),
        .rtc_re_o    (rtc_re_o),
        .rtc_rdata_i (rtc_rdata_i),
        .rdata_o     (rdata_sel)
    );

endmodule

// File: rtl/twi_checker.sv
module twi_checker (
    input logic clk,
    input logic rst_n,
    input logic oe,
    input logic mw,
    input logic mr,
    input logic rw,
    input logic rr,
    input logic scl_s,
    input logic start_det,
    input logic stop_det
);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mw, mr, rw, rr}) <= 1);                        // R12

    AST_START_FREES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !oe);                                        // R2

    AST_STOP_FREES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !oe);                                         // R3

    AST_STOP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !(mw | mr | rw | rr));                        // R3

    AST_OE_AT_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !$past(scl_s));                              // R11

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mw | rw) |=> !(mw | rw));                                 // R7

endmodule

bind dual_id_twi_slave twi_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe        (sda_oe_o),
    .mw        (mem_we_o),
    .mr        (mem_re_o),
    .rw        (rtc_we_o),
    .rr        (rtc_re_o),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det)
);

// File: tb/sim_dual_id_twi_slave.sv
module sim_dual_id_twi_slave;

    localparam int Q    = 10;
    localparam int WD   = 150000;
    localparam logic [2:0] DSEL = 3'b010;
    // {target (0 mem, 1 clock), pointer, data}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 8'h10, 8'hA5}, {1'b1, 8'h03, 8'h3C}, {1'b0, 8'h03, 8'h96},
        {1'b1, 8'h0A, 8'h01}, {1'b0, 8'h7F, 8'hFF}, {1'b1, 8'h00, 8'h80}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic [7:0] mem_addr, rtc_addr8;
    logic [3:0] rtc_addr;
    logic [7:0] mem_wd, rtc_wd, mem_rd, rtc_rd;
    logic mem_we, mem_re, rtc_we, rtc_re;
    wire  sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    dual_id_twi_slave u0 (
        .clk(clk), .rst_n(rst_n), .dev_sel_i(DSEL),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wd), .mem_we_o(mem_we),
        .mem_re_o(mem_re), .mem_rdata_i(mem_rd),
        .rtc_addr_o(rtc_addr), .rtc_wdata_o(rtc_wd), .rtc_we_o(rtc_we),
        .rtc_re_o(rtc_re), .rtc_rdata_i(rtc_rd)
    );

    logic [7:0] mem_m [256], mem_ref [256];
    logic [7:0] rtc_m [16],  rtc_ref [16];
    assign rtc_addr8 = {4'h0, rtc_addr};
    assign mem_rd = mem_m[mem_addr];
    assign rtc_rd = rtc_m[rtc_addr];

    int n_chk = 0, n_err = 0, cyc = 0;
    int we_cnt = 0, re_cnt = 0, bad_oe = 0, bad_ovl = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = 8'(i) ^ 8'h5A; mem_ref[i] = 8'(i) ^ 8'h5A;
        end
        for (int i = 0; i < 16; i++) begin
            rtc_m[i] = 8'(i) ^ 8'hC3; rtc_ref[i] = 8'(i) ^ 8'hC3;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) mem_m[mem_addr] <= mem_wd;
            if (rtc_we) rtc_m[rtc_addr] <= rtc_wd;
            if (mem_we || rtc_we) we_cnt <= we_cnt + 1;
            if (mem_re || rtc_re) re_cnt <= re_cnt + 1;
            if ($countones({mem_we, mem_re, rtc_we, rtc_re}) > 1) bad_ovl <= bad_ovl + 1;
            if (sda_oe && !oe_prev && scl_m) bad_oe <= bad_oe + 1;
        end
        oe_prev <= sda_oe;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD && !done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired act=%0d exp<%0d cycles", cyc, WD);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(output logic [7:0] dat, input logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            dat[i] = r;
        end
        clk_bit(~ack, r);
    endtask

    function automatic logic [7:0] adr(input logic rtc, input logic rd);
        return {rtc ? 4'b1101 : 4'b1010, DSEL, rd};
    endfunction

    task automatic set_ptr(input logic rtc, input logic [7:0] p, output logic ok);
        logic a1, a2;
        bus_start();
        send_byte(adr(rtc, 1'b0), a1);
        send_byte(p, a2);
        ok = a1 & a2;
    endtask

    task automatic read_one(input logic rtc, input logic [7:0] p, output logic [7:0] v,
                            output logic ok);
        logic a1, a2;
        set_ptr(rtc, p, a1);
        bus_start();
        send_byte(adr(rtc, 1'b1), a2);
        recv_byte(v, 1'b0);
        bus_stop();
        ok = a1 & a2;
    endtask

    initial begin
        logic ok, ak, b;
        logic [7:0] v;
        int w0, r0;

        // R13: reset state
        repeat (4) @(negedge clk);
        chk("R13 oe in reset", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R13 oe/strobes after reset", {28'd0, sda_oe, mem_we | rtc_we, mem_re, rtc_re}, 32'd0);

        // R1: address byte without Start
        scl_m = 1'b0; wq();
        w0 = we_cnt;
        send_byte(adr(1'b0, 1'b0), ak);
        chk("R1 no ack without start", {31'd0, ak}, 32'd0);
        send_byte(8'h00, ak);
        chk("R1 no strobe without start", 32'(we_cnt - w0), 32'd0);
        bus_stop();

        // vector walk: write one byte, read it back (R4 R5 R6 R7 R9)
        for (int k = 0; k < 6; k++) begin
            logic tg;
            logic [7:0] p, dv;
            {tg, p, dv} = VEC[k];
            set_ptr(tg, p, ok);
            send_byte(dv, ak);
            bus_stop();
            chk("R6 acks on write", {30'd0, ok, ak}, 32'd3);
            if (tg) rtc_ref[p[3:0]] = dv; else mem_ref[p] = dv;
            read_one(tg, p, v, ok);
            chk("R9 read back", {23'd0, ok, v}, {23'd0, 1'b1, tg ? rtc_ref[p[3:0]] : mem_ref[p]});
        end
        // R5: same pointer on both targets stays separate
        read_one(1'b0, 8'h03, v, ok);
        chk("R5 memory kept", {24'd0, v}, {24'd0, mem_ref[3]});
        read_one(1'b1, 8'h03, v, ok);
        chk("R5 clock kept", {24'd0, v}, {24'd0, rtc_ref[3]});

        // R5: unknown identity is ignored
        w0 = we_cnt;
        bus_start();
        send_byte({4'b0101, DSEL, 1'b0}, ak);
        chk("R5 unknown id nack", {31'd0, ak}, 32'd0);
        send_byte(8'h00, ak);
        send_byte(8'h11, ak);
        chk("R5 unknown id no write", 32'(we_cnt - w0), 32'd0);
        bus_stop();

        // R4: device-select mismatch
        bus_start();
        send_byte({4'b1010, 3'b101, 1'b0}, ak);
        chk("R4 dev_sel mismatch nack", {31'd0, ak}, 32'd0);
        bus_stop();

        // R7 R8: sequential memory write across the top
        w0 = we_cnt;
        set_ptr(1'b0, 8'hFE, ok);
        send_byte(8'h11, ak); send_byte(8'h22, b); ak &= b; send_byte(8'h33, b); ak &= b;
        bus_stop();
        mem_ref[8'hFE] = 8'h11; mem_ref[8'hFF] = 8'h22; mem_ref[8'h00] = 8'h33;
        chk("R7 three writes acked", {30'd0, ok, ak}, 32'd3);
        chk("R7 write strobe count", 32'(we_cnt - w0), 32'd3);

        // R8 R9 R10: sequential read with wrap and final NACK
        set_ptr(1'b0, 8'hFE, ok);
        bus_start();
        r0 = re_cnt;
        send_byte(adr(1'b0, 1'b1), ak);
        recv_byte(v, 1'b1); chk("R9 seq byte 0", {24'd0, v}, {24'd0, mem_ref[8'hFE]});
        recv_byte(v, 1'b1); chk("R9 seq byte 1", {24'd0, v}, {24'd0, mem_ref[8'hFF]});
        recv_byte(v, 1'b0); chk("R8 wrap read", {24'd0, v}, {24'd0, mem_ref[8'h00]});
        chk("R10 sda released after nack", {31'd0, sda_oe}, 32'd0);
        wq();
        chk("R10 fetch count", 32'(re_cnt - r0), 32'd3);
        bus_stop();

        // R8: clock port wraps at 15
        set_ptr(1'b1, 8'h0F, ok);
        send_byte(8'h5C, ak); send_byte(8'hC5, b);
        bus_stop();
        rtc_ref[15] = 8'h5C; rtc_ref[0] = 8'hC5;
        set_ptr(1'b1, 8'h0F, ok);
        bus_start();
        send_byte(adr(1'b1, 1'b1), ak);
        recv_byte(v, 1'b1); chk("R8 clock last reg", {24'd0, v}, {24'd0, rtc_ref[15]});
        recv_byte(v, 1'b0); chk("R8 clock wrapped", {24'd0, v}, {24'd0, rtc_ref[0]});
        bus_stop();

        // R3: Stop in the middle of a data byte
        w0 = we_cnt;
        set_ptr(1'b0, 8'h40, ok);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, b);
        bus_stop();
        scl_m = 1'b0; wq();
        send_byte(8'h77, ak);
        chk("R3 no ack after stop", {31'd0, ak}, 32'd0);
        send_byte(8'h77, ak);
        bus_stop();
        chk("R3 no write after stop", 32'(we_cnt - w0), 32'd0);
        read_one(1'b0, 8'h40, v, ok);
        chk("R3 location unchanged", {24'd0, v}, {24'd0, mem_ref[8'h40]});

        // R2: repeated Start in the middle of a data byte
        w0 = we_cnt;
        set_ptr(1'b0, 8'h50, ok);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, b);
        set_ptr(1'b0, 8'h60, ok);
        chk("R2 address after restart acked", {31'd0, ok}, 32'd1);
        send_byte(8'h9A, ak);
        bus_stop();
        mem_ref[8'h60] = 8'h9A;
        chk("R2 single write after restart", 32'(we_cnt - w0), 32'd1);
        read_one(1'b0, 8'h60, v, ok);
        chk("R2 new data", {24'd0, v}, {24'd0, mem_ref[8'h60]});
        read_one(1'b0, 8'h50, v, ok);
        chk("R2 abandoned byte not written", {24'd0, v}, {24'd0, mem_ref[8'h50]});

        chk("R11 sda pulled only while scl low", bad_oe, 32'd0);
        chk("R12 strobes exclusive", bad_ovl, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule